// File: doc/BRIEF.md
# Supply-Loss Access Gate with Timed Reset

This block sits between a host access port and a byte-wide storage array with time registers, and decides from two digital supply-status flags whether any access may reach the storage. One flag says the main supply is above the write-protect level; the other says it is above the battery-switch level. Both come from analog comparators outside the block, arrive without timing relation to the system clock, and pass through a two-stage synchroniser before any decision uses them.

While the supply is below the write-protect level the block refuses every access: no write strobe reaches the storage and the read output drive stays off. In the same cycle it pulls its active-low reset output low. When the supply returns, the reset output stays low for a recovery interval, counted in system clock cycles, before it releases. An access that was in progress when the supply failed is cancelled. It stays cancelled until the host drops the request, even if the supply comes back first.

The block also controls power routing. It selects the backup battery only when the supply is below both levels, that is, below the lower of the two. The battery path stays disconnected from manufacture until the first time the supply is seen above the write-protect level. After that the connection holds through resets and supply loss, and only a factory-clear input can open it again.

Top module: `pwr_gate`

## Requirements
- R1: Each supply-status input takes effect exactly two clock edges after it changes, because of the two-stage synchroniser. A change is not visible after one edge.
- R2: While the synchronised write-protect flag is low, `mem_wr` and `mem_oe` are both 0 whatever the request inputs are.
- R3: `rst_n_out` is 0 in the same cycle that access becomes blocked. It stays 0 for as long as the synchronised write-protect flag is low.
- R4: After the synchronised write-protect flag rises, `rst_n_out` goes to 1 after exactly `RECOVER_CYC` further clock edges. If the flag drops during the count, the count starts again from the next rise.
- R5: `on_backup` is 1 only when `batt_link` is 1 and both synchronised flags are low. With only one of the two flags low, the main supply stays selected (`on_backup` = 0).
- R6: `batt_link` is 0 after a factory clear. It becomes 1 one edge after the synchronised write-protect flag is first high. Once set, it stays 1 through `rst` and through supply loss.
- R7: While `factory_clr` is 1, `batt_link` is 0, even with the supply good.
- R8: If `acc_req` is 1 while access is blocked, the request stays refused (`mem_wr` = `mem_oe` = 0) until `acc_req` returns to 0, even after the supply recovers.
- R9: When access is allowed and `acc_req` is 1, `acc_wr` = 1 gives `mem_wr` = 1 and `mem_oe` = 0, and `acc_wr` = 0 gives `mem_oe` = 1 and `mem_wr` = 0.
- R10: While `rst` is 1, and until the supply flags have been synchronised as good, `rst_n_out` is 0 and `mem_wr` and `mem_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (does not open the battery path) |
| factory_clr | input | 1 | Clears the battery connection latch |
| wp_ok_async | input | 1 | Supply above write-protect level, asynchronous |
| bsw_ok_async | input | 1 | Supply above battery-switch level, asynchronous |
| acc_req | input | 1 | Host access in progress |
| acc_wr | input | 1 | 1 = write, 0 = read |
| mem_wr | output | 1 | Write strobe to storage |
| mem_oe | output | 1 | Read data drive enable |
| rst_n_out | output | 1 | Active-low system reset |
| on_backup | output | 1 | 1 selects the backup battery as supply |
| batt_link | output | 1 | 1 connects the battery path |

## Verification
Blocking an access and asserting the reset output fall in the same cycle. The bench provokes this by holding a write request while it lowers the write-protect input. After the two synchroniser edges it samples once and requires both `mem_wr` = 0 and `rst_n_out` = 0 in that one sample. It then raises the supply again with the request still held, runs past the recovery interval, and requires the write to stay refused until the request has been released and made again.

// File: rtl/pwr_gate_pkg.sv
package pwr_gate_pkg;

    localparam int SYNC_DEPTH = 2;

    typedef struct packed {
        logic wp_ok;
        logic bsw_ok;
    } supply_t;

    typedef struct packed {
        logic req;
        logic wr;
    } access_t;

    typedef struct packed {
        logic wr;
        logic oe;
    } mem_ctl_t;

    // Battery is taken only when the supply is below both levels.
    function automatic logic backup_needed(supply_t s);
        return !s.wp_ok && !s.bsw_ok;
    endfunction

    function automatic mem_ctl_t decode_access(access_t a, logic allow);
        mem_ctl_t m;
        m.wr = allow && a.req && a.wr;
        m.oe = allow && a.req && !a.wr;
        return m;
    endfunction

endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/pg_recovery.sv
module pg_recovery #(
    parameter int RECOVER_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic wp_ok,
    output logic rst_n_o
);
    localparam int CNT_W = $clog2(RECOVER_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(RECOVER_CYC);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !wp_ok) cnt <= LOAD;
        else if (cnt != '0) cnt <= cnt - CNT_W'(1);
    end

    assign rst_n_o = wp_ok && (cnt == '0);

    // R4
    release_after_good_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_n_o) |-> $past(wp_ok));
endmodule

// File: rtl/pg_batt.sv
module pg_batt
    import pwr_gate_pkg::*;
(
    input  logic    clk,
    input  logic    factory_clr,
    input  supply_t sup,
    output logic    link,
    output logic    use_batt
);
    always_ff @(posedge clk) begin
        if (factory_clr) link <= 1'b0;
        else if (sup.wp_ok) link <= 1'b1;
    end

    assign use_batt = link && backup_needed(sup);

    // R6
    link_sticky_chk: assert property (@(posedge clk) disable iff (factory_clr)
        link |=> link);
    // R7
    clear_opens_chk: assert property (@(posedge clk)
        factory_clr |=> !link);
endmodule

// File: rtl/pg_access.sv
module pg_access
    import pwr_gate_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     allow,
    input  access_t  acc,
    output mem_ctl_t mem
);
    logic cancelled;

    always_ff @(posedge clk) begin
        if (rst) cancelled <= 1'b0;
        else if (!acc.req) cancelled <= 1'b0;
        else if (!allow) cancelled <= 1'b1;
    end

    assign mem = decode_access(acc, allow && !cancelled);

    // R8
    cancel_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (acc.req && !allow) |=> (!acc.req || (!mem.wr && !mem.oe)));
endmodule

// File: rtl/pwr_gate.sv
module pwr_gate
    import pwr_gate_pkg::*;
#(
    parameter int RECOVER_CYC = 8_750_000
) (
    input  logic clk,
    input  logic rst,
    input  logic factory_clr,
    input  logic wp_ok_async,
    input  logic bsw_ok_async,
    input  logic acc_req,
    input  logic acc_wr,
    output logic mem_wr,
    output logic mem_oe,
    output logic rst_n_out,
    output logic on_backup,
    output logic batt_link
);
    logic [1:0] sync_q;
    supply_t    sup;
    access_t    acc;
    mem_ctl_t   mem;

    pg_sync #(.W(2), .STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({wp_ok_async, bsw_ok_async}),
        .q   (sync_q)
    );

    assign sup.wp_ok  = sync_q[1];
    assign sup.bsw_ok = sync_q[0];
    assign acc.req    = acc_req;
    assign acc.wr     = acc_wr;

    pg_recovery #(.RECOVER_CYC(RECOVER_CYC)) u_rec (
        .clk     (clk),
        .rst     (rst),
        .wp_ok   (sup.wp_ok),
        .rst_n_o (rst_n_out)
    );

    pg_batt u_batt (
        .clk         (clk),
        .factory_clr (factory_clr),
        .sup         (sup),
        .link        (batt_link),
        .use_batt    (on_backup)
    );

    pg_access u_acc (
        .clk   (clk),
        .rst   (rst),
        .allow (sup.wp_ok),
        .acc   (acc),
        .mem   (mem)
    );

    assign mem_wr = mem.wr;
    assign mem_oe = mem.oe;

    // R2
    blocked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !sup.wp_ok |-> (!mem_wr && !mem_oe));
    // R3
    reset_with_block_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sup.wp_ok) |-> !rst_n_out);
    // R5
    backup_needs_link_chk: assert property (@(posedge clk) disable iff (rst)
        on_backup |-> (batt_link && !sup.wp_ok));
    // R9
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({mem_wr, mem_oe}) <= 1);
endmodule

// File: tb/pwr_gate_test.sv
module pwr_gate_test;
    localparam int N = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic factory_clr = 1'b1;
    logic wp_raw = 1'b0;
    logic bs_raw = 1'b0;
    logic req = 1'b0;
    logic wr = 1'b0;
    logic mem_wr, mem_oe, rst_n_out, on_backup, batt_link;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwr_gate #(.RECOVER_CYC(N)) uut (
        .clk(clk), .rst(rst), .factory_clr(factory_clr),
        .wp_ok_async(wp_raw), .bsw_ok_async(bs_raw),
        .acc_req(req), .acc_wr(wr),
        .mem_wr(mem_wr), .mem_oe(mem_oe), .rst_n_out(rst_n_out),
        .on_backup(on_backup), .batt_link(batt_link)
    );

    // Entry: [7]wp [6]bs [5]req [4]wr | [3]mem_wr [2]mem_oe [1]rst_n [0]on_backup
    localparam logic [7:0] VEC [8] = '{
        8'b1111_1010,
        8'b1110_0110,
        8'b1011_1010,
        8'b0111_0000,
        8'b0010_0001,
        8'b0000_0001,
        8'b1101_0010,
        8'b1010_0110
    };

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
            summary();
        end
    end

    initial begin
        step(4);
        // R10 reset state
        check("R10 rst_n in reset", rst_n_out, 1'b0);
        check("R10 mem_wr in reset", mem_wr, 1'b0);
        check("R6 link after factory clear", batt_link, 1'b0);
        rst = 1'b0;
        factory_clr = 1'b0;
        req = 1'b1; wr = 1'b1;
        step(3);
        check("R10 write refused before supply good", mem_wr, 1'b0);
        check("R5 no backup before first power-up", on_backup, 1'b0);
        req = 1'b0;

        // R6 first power-up connects battery, R4 timed release
        wp_raw = 1'b1; bs_raw = 1'b1;
        step(2);
        check("R6 link not yet set", batt_link, 1'b0);
        step(1);
        check("R6 link set after first good supply", batt_link, 1'b1);
        step(N - 2);
        check("R4 reset still low at N+1", rst_n_out, 1'b0);
        step(1);
        check("R4 reset released at N+2", rst_n_out, 1'b1);

        // R6 link survives rst
        rst = 1'b1; step(2); rst = 1'b0; step(1);
        check("R6 link kept through rst", batt_link, 1'b1);
        step(N + 4);

        // Vector table (R2 R3 R5 R9)
        for (int i = 0; i < 8; i++) begin
            req = 1'b0;
            wp_raw = VEC[i][7]; bs_raw = VEC[i][6];
            step(N + 4);
            req = VEC[i][5]; wr = VEC[i][4];
            #0.5;
            check("R9/R2 mem_wr vector", mem_wr, VEC[i][3]);
            check("R9/R2 mem_oe vector", mem_oe, VEC[i][2]);
            check("R3 rst_n vector", rst_n_out, VEC[i][1]);
            check("R5 on_backup vector", on_backup, VEC[i][0]);
            step(1);
        end

        // R1 latency: both flags low with link set
        req = 1'b0; wp_raw = 1'b1; bs_raw = 1'b1;
        step(N + 4);
        wp_raw = 1'b0; bs_raw = 1'b0;
        step(1);
        check("R1 no effect after one edge", on_backup, 1'b0);
        check("R1 reset not yet after one edge", rst_n_out, 1'b1);
        step(1);
        check("R1 backup after two edges", on_backup, 1'b1);
        check("R6 link kept through supply loss", batt_link, 1'b1);

        // R4 restart on glitch during recovery
        wp_raw = 1'b1; bs_raw = 1'b1;
        step(10);
        wp_raw = 1'b0;
        step(3);
        wp_raw = 1'b1;
        step(N + 1);
        check("R4 restarted count still low", rst_n_out, 1'b0);
        step(1);
        check("R4 restarted count released", rst_n_out, 1'b1);

        // R8 and R3 in the same cycle
        req = 1'b1; wr = 1'b1;
        step(1);
        check("R9 write granted", mem_wr, 1'b1);
        wp_raw = 1'b0;
        step(2);
        check("R8 write cancelled on supply loss", mem_wr, 1'b0);
        check("R3 reset asserted same cycle", rst_n_out, 1'b0);
        wp_raw = 1'b1;
        step(N + 4);
        check("R4 reset back after recovery", rst_n_out, 1'b1);
        check("R8 cancelled write stays refused", mem_wr, 1'b0);
        req = 1'b0; step(1);
        req = 1'b1; step(1);
        check("R8 fresh request granted", mem_wr, 1'b1);
        req = 1'b0;

        // R7 factory clear dominates good supply
        factory_clr = 1'b1;
        step(1);
        check("R7 link cleared", batt_link, 1'b0);
        step(3);
        check("R7 link held open", batt_link, 1'b0);
        factory_clr = 1'b0;
        step(1);
        check("R6 link reconnects on good supply", batt_link, 1'b1);

        done = 1'b1;
        summary();
    end
endmodule